// File: doc/BRIEF.md
# AHB Error Capture Monitor

This block sits passively on an AHB bus. It follows the address phase of every transfer, keeps the control and address values of the transfer now in its data phase, and freezes a copy of them when that transfer gets an error response. A separate strobe for correctable errors (from an error-correcting memory path) triggers the same capture and marks the record as correctable. Each capture sets a new-error flag and drives a level interrupt. Software reads the frozen record over an APB slave port. It then clears the flag to re-arm that record.

There are two capture records. Each one has a filter that picks which kinds of event it takes: read errors, write errors or correctable strobes. An event goes only to the lowest-numbered record whose filter accepts it. If that record is still holding an earlier capture, the event sets a sticky overflow bit and leaves the frozen contents alone. Only the first error response inside a burst is reported. Further error responses on later beats of that burst are dropped.

Top module: `ahb_err_monitor`

## Requirements
- R1: An address phase is recorded only when `hready` is 1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). An error response is matched only against a recorded transfer, and it captures that transfer's address, `hwrite`, `hsize` and `hmaster`.
- R2: A bus error is the first cycle of an error response (`hresp` = 2'b01 with `hready` = 0). It loads the accepting record and sets its NE bit. While NE is 1 the captured fields and address stay unchanged.
- R3: `irq` is 1 exactly when any record has NE set. It only rises the cycle after a bus error or a correctable strobe.
- R4: A cycle with `corr_err` = 1 captures the transfer currently in its data phase and sets CE = 1. A bus-error capture sets CE = 0. If both happen in one cycle, the bus error wins.
- R5: Writing the status word clears NE, CE and ME wherever the written bits [8], [9] and [10] are 0. Bits written as 1 leave those flags unchanged. Once NE is 0 the record captures again.
- R6: After reset, all flags are 0, all captured fields and addresses are 0, all filters read 3'b111, and capture works with no setup.
- R7: An event goes only to the first record (record 0 before record 1) whose filter accepts it. No event ever loads two records. An event that no filter accepts changes nothing.
- R8: After a bus error, further error responses are ignored until an address phase with `hready` = 1 and `htrans` IDLE or NONSEQ ends the burst.
- R9: An event routed to a record whose NE is already 1 sets that record's ME bit. It does not change that record's captured contents.
- R10: Register map. Record k sits at byte offset 16·k. Offset +0x0 is status: `hsize` [2:0], `hmaster` [6:3], `hwrite` [7], NE [8], CE [9], ME [10], all other bits 0. Offset +0x4 is the failing address. Offset +0x8 is the filter in bits [2:0]. Offset +0xC reads 0. A write takes effect when `psel`, `penable` and `pwrite` are all 1.
- R11: Filter bit 0 accepts read errors, bit 1 accepts write errors and bit 2 accepts correctable strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the bus and APB |
| rst_n | input | 1 | Asynchronous active-low reset |
| haddr | input | AW | Observed AHB address |
| htrans | input | 2 | Observed transfer type |
| hwrite | input | 1 | Observed direction (1 = write) |
| hsize | input | 3 | Observed transfer size |
| hmaster | input | 4 | Observed master number |
| hready | input | 1 | Observed transfer-done signal |
| hresp | input | 2 | Observed slave response |
| corr_err | input | 1 | Correctable-error strobe, one cycle per event |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction |
| paddr | input | PA_W | APB byte address (5 bits by default) |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, combinational from paddr |
| irq | output | 1 | Level interrupt, OR of the NE flags |

## Verification
The assertions assume that the bus follows the AHB error-response protocol. That means two response cycles: the first with `hready` low, the second with `hready` high. They also assume that `corr_err` is a single-cycle strobe and that software never clears NE in the same cycle that an event hits that record. The bench drives the bus one cycle at a time on the falling edge, always builds complete two-cycle error responses, and keeps APB writes apart from bus events. Bursts are built from legal NONSEQ/SEQ/BUSY/IDLE sequences, so the burst-suppression rule is tested on patterns a real master can produce.

// File: rtl/ahbmon_pkg.sv
`timescale 1ns/1ps
package ahbmon_pkg;

  localparam logic [1:0] TRANS_IDLE   = 2'b00;
  localparam logic [1:0] TRANS_BUSY   = 2'b01;
  localparam logic [1:0] TRANS_NONSEQ = 2'b10;
  localparam logic [1:0] TRANS_SEQ    = 2'b11;
  localparam logic [1:0] RESP_ERROR   = 2'b01;

  localparam int STAT_NE = 8;
  localparam int STAT_CE = 9;
  localparam int STAT_ME = 10;
  localparam int FILT_W  = 3;

  typedef enum logic [1:0] {
    EV_RD   = 2'd0,
    EV_WR   = 2'd1,
    EV_CORR = 2'd2
  } ev_kind_e;

  // packed so that it lands directly on status bits [7:0]
  typedef struct packed {
    logic       wr;
    logic [3:0] mst;
    logic [2:0] sz;
  } xfer_ctl_t;

endpackage

// File: rtl/ahbmon_tracker.sv
`timescale 1ns/1ps
module ahbmon_tracker
  import ahbmon_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   haddr,
  input  logic [1:0]      htrans,
  input  logic            hwrite,
  input  logic [2:0]      hsize,
  input  logic [3:0]      hmaster,
  input  logic            hready,
  input  logic [1:0]      hresp,
  input  logic            corr_err,
  output logic            ev_valid,
  output ev_kind_e        ev_kind,
  output xfer_ctl_t       ev_ctl,
  output logic [AW-1:0]   ev_addr
);

  logic          dph_vld_q, dph_vld_d;
  xfer_ctl_t     dph_ctl_q, dph_ctl_d;
  logic [AW-1:0] dph_addr_q, dph_addr_d;
  logic          dph_en;
  logic          hold_q, hold_d;
  logic          active_phase;
  logic          bus_err, bus_ev;

  assign active_phase = (htrans == TRANS_NONSEQ) || (htrans == TRANS_SEQ);
  assign bus_err      = (hresp == RESP_ERROR) && !hready && dph_vld_q;
  assign bus_ev       = bus_err && !hold_q;

  always_comb begin
    dph_vld_d  = dph_vld_q;
    dph_ctl_d  = dph_ctl_q;
    dph_addr_d = dph_addr_q;
    dph_en     = 1'b0;
    if (hready) begin
      dph_vld_d = active_phase;
      if (active_phase) begin
        dph_en     = 1'b1;
        dph_ctl_d  = '{wr: hwrite, mst: hmaster, sz: hsize};
        dph_addr_d = haddr;
      end
    end
  end

  // burst hold: set by any error response, dropped when the burst ends
  always_comb begin
    hold_d = hold_q;
    if (bus_err)
      hold_d = 1'b1;
    else if (hready && ((htrans == TRANS_IDLE) || (htrans == TRANS_NONSEQ)))
      hold_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_vld_q <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      dph_vld_q <= dph_vld_d;
      hold_q    <= hold_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dph_ctl_q  <= '0;
      dph_addr_q <= '0;
    end else if (dph_en) begin
      dph_ctl_q  <= dph_ctl_d;
      dph_addr_q <= dph_addr_d;
    end
  end

  always_comb begin
    ev_valid = bus_ev || corr_err;
    ev_ctl   = dph_ctl_q;
    ev_addr  = dph_addr_q;
    if (bus_ev)
      ev_kind = dph_ctl_q.wr ? EV_WR : EV_RD;
    else
      ev_kind = EV_CORR;
  end

endmodule

// File: rtl/ahbmon_capset.sv
`timescale 1ns/1ps
module ahbmon_capset
  import ahbmon_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_hit,
  input  ev_kind_e          ev_kind,
  input  xfer_ctl_t         ev_ctl,
  input  logic [AW-1:0]     ev_addr,
  input  logic              wr_status,
  input  logic              wr_filter,
  input  logic [31:0]       wdata,
  output logic              accept,
  output logic              ne_o,
  output logic              me_o,
  output logic [31:0]       status_o,
  output logic [AW-1:0]     addr_o,
  output logic [FILT_W-1:0] filter_o
);

  logic              ne_q, ne_d;
  logic              ce_q, ce_d;
  logic              me_q, me_d;
  xfer_ctl_t         ctl_q;
  logic [AW-1:0]     addr_q;
  logic              cap_en;
  logic [FILT_W-1:0] filt_q, filt_d;

  always_comb begin
    unique case (ev_kind)
      EV_RD:   accept = filt_q[0];
      EV_WR:   accept = filt_q[1];
      EV_CORR: accept = filt_q[2];
      default: accept = 1'b0;
    endcase
  end

  always_comb begin
    ne_d   = ne_q;
    ce_d   = ce_q;
    me_d   = me_q;
    cap_en = 1'b0;
    filt_d = filt_q;
    if (wr_status) begin
      ne_d = ne_q & wdata[STAT_NE];
      ce_d = ce_q & wdata[STAT_CE];
      me_d = me_q & wdata[STAT_ME];
    end
    if (ev_hit) begin
      if (!ne_q) begin
        cap_en = 1'b1;
        ne_d   = 1'b1;
        ce_d   = (ev_kind == EV_CORR);
      end else begin
        me_d = 1'b1;
      end
    end
    if (wr_filter)
      filt_d = wdata[FILT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ne_q   <= 1'b0;
      ce_q   <= 1'b0;
      me_q   <= 1'b0;
      filt_q <= '1;
    end else begin
      ne_q   <= ne_d;
      ce_q   <= ce_d;
      me_q   <= me_d;
      filt_q <= filt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      addr_q <= '0;
    end else if (cap_en) begin
      ctl_q  <= ev_ctl;
      addr_q <= ev_addr;
    end
  end

  assign ne_o     = ne_q;
  assign me_o     = me_q;
  assign status_o = {21'd0, me_q, ce_q, ne_q, ctl_q};
  assign addr_o   = addr_q;
  assign filter_o = filt_q;

endmodule

// File: rtl/ahbmon_regif.sv
`timescale 1ns/1ps
module ahbmon_regif
  import ahbmon_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 2,
  localparam int SEL_W = $clog2(NSETS),
  localparam int PA_W  = 4 + SEL_W
) (
  input  logic                     psel,
  input  logic                     penable,
  input  logic                     pwrite,
  input  logic [PA_W-1:0]          paddr,
  input  logic [NSETS*32-1:0]      status_flat,
  input  logic [NSETS*AW-1:0]      addr_flat,
  input  logic [NSETS*FILT_W-1:0]  filter_flat,
  output logic [NSETS-1:0]         wr_status,
  output logic [NSETS-1:0]         wr_filter,
  output logic [31:0]              prdata
);

  localparam logic [1:0] W_STATUS = 2'd0;
  localparam logic [1:0] W_ADDR   = 2'd1;
  localparam logic [1:0] W_FILTER = 2'd2;

  logic [SEL_W-1:0] sel;
  logic [1:0]       word;
  logic             wr_access;

  assign sel       = paddr[PA_W-1:4];
  assign word      = paddr[3:2];
  assign wr_access = psel && penable && pwrite;

  always_comb begin
    wr_status = '0;
    wr_filter = '0;
    prdata    = '0;
    for (int k = 0; k < NSETS; k++) begin
      if (sel == SEL_W'(k)) begin
        wr_status[k] = wr_access && (word == W_STATUS);
        wr_filter[k] = wr_access && (word == W_FILTER);
        unique case (word)
          W_STATUS: prdata = status_flat[k*32 +: 32];
          W_ADDR:   prdata = 32'(addr_flat[k*AW +: AW]);
          W_FILTER: prdata = 32'(filter_flat[k*FILT_W +: FILT_W]);
          default:  prdata = '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/ahb_err_monitor.sv
`timescale 1ns/1ps
module ahb_err_monitor
  import ahbmon_pkg::*;
#(
  parameter int AW    = 32,
  parameter int NSETS = 2,
  localparam int PA_W = 4 + $clog2(NSETS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   haddr,
  input  logic [1:0]      htrans,
  input  logic            hwrite,
  input  logic [2:0]      hsize,
  input  logic [3:0]      hmaster,
  input  logic            hready,
  input  logic [1:0]      hresp,
  input  logic            corr_err,
  input  logic            psel,
  input  logic            penable,
  input  logic            pwrite,
  input  logic [PA_W-1:0] paddr,
  input  logic [31:0]     pwdata,
  output logic [31:0]     prdata,
  output logic            irq
);

  logic [1:0]              rst_sync_q;
  logic                    rst_sync_n;
  logic                    ev_valid;
  ev_kind_e                ev_kind;
  xfer_ctl_t               ev_ctl;
  logic [AW-1:0]           ev_addr;
  logic [NSETS-1:0]        accept_vec, hit_vec;
  logic [NSETS-1:0]        ne_vec, me_vec;
  logic [NSETS-1:0]        wr_status, wr_filter;
  logic [NSETS*32-1:0]     status_flat;
  logic [NSETS*AW-1:0]     cap_addr_flat;
  logic [NSETS*FILT_W-1:0] filter_flat;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  ahbmon_tracker #(.AW(AW)) u_tracker (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .haddr    (haddr),
    .htrans   (htrans),
    .hwrite   (hwrite),
    .hsize    (hsize),
    .hmaster  (hmaster),
    .hready   (hready),
    .hresp    (hresp),
    .corr_err (corr_err),
    .ev_valid (ev_valid),
    .ev_kind  (ev_kind),
    .ev_ctl   (ev_ctl),
    .ev_addr  (ev_addr)
  );

  // priority routing: the lowest record whose filter accepts owns the event
  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int k = 0; k < NSETS; k++) begin
      hit_vec[k] = ev_valid && accept_vec[k] && !taken;
      taken      = taken || accept_vec[k];
    end
  end

  for (genvar g = 0; g < NSETS; g++) begin : g_set
    ahbmon_capset #(.AW(AW)) u_set (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .ev_hit    (hit_vec[g]),
      .ev_kind   (ev_kind),
      .ev_ctl    (ev_ctl),
      .ev_addr   (ev_addr),
      .wr_status (wr_status[g]),
      .wr_filter (wr_filter[g]),
      .wdata     (pwdata),
      .accept    (accept_vec[g]),
      .ne_o      (ne_vec[g]),
      .me_o      (me_vec[g]),
      .status_o  (status_flat[g*32 +: 32]),
      .addr_o    (cap_addr_flat[g*AW +: AW]),
      .filter_o  (filter_flat[g*FILT_W +: FILT_W])
    );
  end

  ahbmon_regif #(.AW(AW), .NSETS(NSETS)) u_regif (
    .psel        (psel),
    .penable     (penable),
    .pwrite      (pwrite),
    .paddr       (paddr),
    .status_flat (status_flat),
    .addr_flat   (cap_addr_flat),
    .filter_flat (filter_flat),
    .wr_status   (wr_status),
    .wr_filter   (wr_filter),
    .prdata      (prdata)
  );

  assign irq = |ne_vec;

endmodule

// File: rtl/ahbmon_checker.sv
`timescale 1ns/1ps
module ahbmon_checker #(
  parameter int AW    = 32,
  parameter int NSETS = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          hresp,
  input logic                hready,
  input logic                corr_err,
  input logic                irq,
  input logic [NSETS-1:0]    ne_vec,
  input logic [NSETS-1:0]    me_vec,
  input logic [NSETS*AW-1:0] addr_flat
);

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(corr_err || ((hresp == 2'b01) && !hready))); // R3

  AST_SINGLE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ne_vec & ~$past(ne_vec))); // R7

  for (genvar g = 0; g < NSETS; g++) begin : g_chk
    AST_FROZEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (ne_vec[g] && $past(ne_vec[g])) |-> $stable(addr_flat[g*AW +: AW])); // R2

    AST_OVERFLOW_NEEDS_NE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(me_vec[g]) |-> $past(ne_vec[g])); // R9
  end

endmodule

bind ahb_err_monitor ahbmon_checker #(.AW(AW), .NSETS(NSETS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .hresp     (hresp),
  .hready    (hready),
  .corr_err  (corr_err),
  .irq       (irq),
  .ne_vec    (ne_vec),
  .me_vec    (me_vec),
  .addr_flat (cap_addr_flat)
);

// File: tb/test_ahb_err_monitor.sv
`timescale 1ns/1ps
module test_ahb_err_monitor;

  localparam int AW = 32;
  localparam logic [1:0] T_IDLE = 2'b00, T_BUSY = 2'b01, T_NSEQ = 2'b10, T_SEQ = 2'b11;
  localparam logic [1:0] R_OK = 2'b00, R_ERR = 2'b01;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize;
  logic [3:0]  hmaster;
  logic        hready;
  logic [1:0]  hresp;
  logic        corr_err;
  logic        psel, penable, pwrite;
  logic [4:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ahb_err_monitor #(.AW(AW), .NSETS(2)) i_ahb_err_monitor (
    .clk(clk), .rst_n(rst_n), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hmaster(hmaster), .hready(hready), .hresp(hresp),
    .corr_err(corr_err), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  // kind: 0 okay transfer, 1 error response, 2 correctable strobe
  // eset: 0 none, 1 record 0, 2 record 1; filters bit0 rd, bit1 wr, bit2 corr
  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic [2:0]  sz;
    logic [3:0]  m;
    logic [1:0]  kind;
    logic [1:0]  eset;
    logic [2:0]  f0;
    logic [2:0]  f1;
  } vec_t;

  localparam vec_t VT [9] = '{
    '{32'h1000_0040, 1'b0, 3'd2, 4'd3,  2'd1, 2'd1, 3'b111, 3'b111},
    '{32'h2000_0104, 1'b1, 3'd1, 4'd5,  2'd1, 2'd1, 3'b111, 3'b111},
    '{32'h3000_0008, 1'b0, 3'd2, 4'd1,  2'd2, 2'd1, 3'b111, 3'b111},
    '{32'h4400_0010, 1'b0, 3'd2, 4'd6,  2'd1, 2'd2, 3'b110, 3'b111},
    '{32'h5000_0020, 1'b1, 3'd0, 4'd7,  2'd1, 2'd2, 3'b101, 3'b111},
    '{32'h6000_0ABC, 1'b1, 3'd2, 4'd9,  2'd2, 2'd2, 3'b011, 3'b100},
    '{32'h7000_0000, 1'b0, 3'd2, 4'd10, 2'd1, 2'd0, 3'b010, 3'b010},
    '{32'h8000_0000, 1'b1, 3'd2, 4'd11, 2'd0, 2'd0, 3'b111, 3'b111},
    '{32'hFFFF_FFFC, 1'b1, 3'd0, 4'd15, 2'd1, 2'd1, 3'b010, 3'b000}
  };

  function automatic logic [31:0] stat(input logic me, ce, ne, w,
                                       input logic [3:0] m, input logic [2:0] sz);
    return {21'd0, me, ce, ne, w, m, sz};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] tr, input logic [31:0] a, input logic w,
                     input logic [2:0] sz, input logic [3:0] m, input logic rdy,
                     input logic [1:0] rsp, input logic ce);
    @(negedge clk);
    htrans = tr; haddr = a; hwrite = w; hsize = sz; hmaster = m;
    hready = rdy; hresp = rsp; corr_err = ce;
  endtask

  task automatic idle();
    cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 4'd0, 1'b1, R_OK, 1'b0);
  endtask

  task automatic err_pair();
    cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 4'd0, 1'b0, R_ERR, 1'b0);
    cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 4'd0, 1'b1, R_ERR, 1'b0);
    idle();
  endtask

  task automatic apb_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0;
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    htrans = T_IDLE; haddr = '0; hwrite = 1'b0; hsize = '0; hmaster = '0;
    hready = 1'b1; hresp = R_OK; corr_err = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) idle();

    // R6 reset state, R11 filter default, R10 map
    for (int k = 0; k < 2; k++) begin
      apb_rd(5'(k*16 + 0), rd); check("R6 status after reset", rd, 32'h0);
      apb_rd(5'(k*16 + 4), rd); check("R6 address after reset", rd, 32'h0);
      apb_rd(5'(k*16 + 8), rd); check("R11 filter after reset", rd, 32'h7);
      apb_rd(5'(k*16 + 12), rd); check("R10 spare word", rd, 32'h0);
    end
    check("R3 irq after reset", {31'd0, irq}, 32'd0);

    // vector table: R1 R2 R4 R7 R11
    foreach (VT[i]) begin
      apb_wr(5'h08, {29'd0, VT[i].f0});
      apb_wr(5'h18, {29'd0, VT[i].f1});
      cyc(T_NSEQ, VT[i].a, VT[i].w, VT[i].sz, VT[i].m, 1'b1, R_OK, 1'b0);
      case (VT[i].kind)
        2'd1: err_pair();
        2'd2: begin
          cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 4'd0, 1'b1, R_OK, 1'b1);
          idle();
        end
        default: idle();
      endcase
      idle();
      for (int k = 0; k < 2; k++) begin
        apb_rd(5'(k*16), rd);
        if (VT[i].eset == 2'(k + 1)) begin
          check("R7 R2 R4 captured status", rd,
                stat(1'b0, VT[i].kind == 2'd2, 1'b1, VT[i].w, VT[i].m, VT[i].sz));
          apb_rd(5'(k*16 + 4), rd);
          check("R1 captured address", rd, VT[i].a);
        end else begin
          check("R7 other record untouched", {29'd0, rd[10:8]}, 32'd0);
        end
      end
      check("R3 irq level", {31'd0, irq}, {31'd0, VT[i].eset != 2'd0});
      apb_wr(5'h00, 32'h0);
      apb_wr(5'h10, 32'h0);
      check("R5 irq after clear", {31'd0, irq}, 32'd0);
    end
    apb_wr(5'h08, 32'h7);
    apb_wr(5'h18, 32'h7);

    // R8 burst: error on beat C, later error on beat D ignored
    cyc(T_NSEQ, 32'h4000_0000, 1'b0, 3'd2, 4'd2, 1'b1, R_OK, 1'b0);
    cyc(T_SEQ,  32'h4000_0004, 1'b0, 3'd2, 4'd2, 1'b1, R_OK, 1'b0);
    cyc(T_SEQ,  32'h4000_0008, 1'b0, 3'd2, 4'd2, 1'b1, R_OK, 1'b0);
    cyc(T_SEQ,  32'h4000_000C, 1'b0, 3'd2, 4'd2, 1'b0, R_ERR, 1'b0);
    cyc(T_SEQ,  32'h4000_000C, 1'b0, 3'd2, 4'd2, 1'b1, R_ERR, 1'b0);
    err_pair();
    idle();
    apb_rd(5'h00, rd); check("R8 burst first error only", rd, stat(1'b0, 1'b0, 1'b1, 1'b0, 4'd2, 3'd2));
    apb_rd(5'h04, rd); check("R8 burst address", rd, 32'h4000_0008);
    apb_rd(5'h10, rd); check("R7 R8 record 1 idle", {29'd0, rd[10:8]}, 32'd0);

    // R9 + R2: new error while NE set
    cyc(T_NSEQ, 32'h9000_0000, 1'b1, 3'd1, 4'd4, 1'b1, R_OK, 1'b0);
    err_pair();
    idle();
    apb_rd(5'h00, rd); check("R9 overflow flag, R2 fields frozen", rd, stat(1'b1, 1'b0, 1'b1, 1'b0, 4'd2, 3'd2));
    apb_rd(5'h04, rd); check("R2 address frozen", rd, 32'h4000_0008);
    apb_rd(5'h10, rd); check("R7 busy owner not passed on", {29'd0, rd[10:8]}, 32'd0);

    // R5 write of ones leaves flags; zeros clear and re-arm
    apb_wr(5'h00, 32'h0000_0700);
    apb_rd(5'h00, rd); check("R5 ones keep flags", rd, stat(1'b1, 1'b0, 1'b1, 1'b0, 4'd2, 3'd2));
    apb_wr(5'h00, 32'h0);
    check("R5 irq cleared", {31'd0, irq}, 32'd0);
    cyc(T_NSEQ, 32'hA000_0010, 1'b0, 3'd0, 4'd8, 1'b1, R_OK, 1'b0);
    err_pair();
    idle();
    apb_rd(5'h04, rd); check("R5 re-armed capture", rd, 32'hA000_0010);
    apb_wr(5'h00, 32'h0);

    // R1 wait state: phase with hready low not sampled
    cyc(T_NSEQ, 32'hB000_0000, 1'b0, 3'd2, 4'd1, 1'b1, R_OK, 1'b0);
    cyc(T_NSEQ, 32'hB000_0100, 1'b1, 3'd2, 4'd1, 1'b0, R_OK, 1'b0);
    err_pair();
    idle();
    apb_rd(5'h04, rd); check("R1 wait-state phase ignored", rd, 32'hB000_0000);
    apb_wr(5'h00, 32'h0);

    // R1 BUSY phase is not a transfer: error response finds nothing
    cyc(T_NSEQ, 32'hC000_0000, 1'b0, 3'd2, 4'd1, 1'b1, R_OK, 1'b0);
    cyc(T_BUSY, 32'hC000_0004, 1'b0, 3'd2, 4'd1, 1'b1, R_OK, 1'b0);
    err_pair();
    idle();
    apb_rd(5'h00, rd); check("R1 BUSY phase not captured", {29'd0, rd[10:8]}, 32'd0);
    check("R3 no irq for BUSY", {31'd0, irq}, 32'd0);

    // R4 bus error and strobe together: bus error wins
    cyc(T_NSEQ, 32'hD000_0000, 1'b1, 3'd2, 4'd3, 1'b1, R_OK, 1'b0);
    cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 4'd0, 1'b0, R_ERR, 1'b1);
    cyc(T_IDLE, 32'h0, 1'b0, 3'd0, 4'd0, 1'b1, R_ERR, 1'b0);
    idle();
    apb_rd(5'h00, rd); check("R4 bus error wins", rd, stat(1'b0, 1'b0, 1'b1, 1'b1, 4'd3, 3'd2));
    apb_rd(5'h10, rd); check("R4 R7 single record", {29'd0, rd[10:8]}, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule